// File: doc/BRIEF.md
# Two-Input Shoot-Through Interlock

This block sits between a controller and the two gate drivers of a half bridge. It takes a separate on-request for the high-side switch (A) and one for the low-side switch (B). Each request is passed to its own registered drive output. The block never lets both drive outputs be on at the same time.

If both requests are high together, the request is treated as invalid. Both outputs are driven low and a contention flag is raised. When one request drops, the other side is released. A permit input forces both outputs low whatever the requests are.

An optional per-input glitch filter ignores any input change that lasts fewer than `FILT_CYCLES` clock cycles. A filtered change reaches the drive register `FILT_CYCLES` cycles late. The interlock decision is taken on the filtered inputs, so a glitch can never briefly turn both sides on. With `FILT_CYCLES` set to 0 the filter is left out and adds no latency.

Top module: `shoot_thru_guard`

## Requirements
- R1: A settled request of A=1, B=1'b0 with permit high gives drv_a_o=1 and drv_b_o=0.
- R2: A settled request of B=1, A=0 with permit high gives drv_b_o=1 and drv_a_o=0.
- R3: Both requests low gives both drive outputs low. Both drive outputs are also low after reset.
- R4: Both filtered requests high gives both drive outputs low and clash_o=1. clash_o is 0 whenever either filtered request is low. drv_a_o and drv_b_o are never high together.
- R5: Recovery from contention depends on which request falls. If A falls while B stays high, drv_b_o goes high. If B falls while A stays high, drv_a_o goes high.
- R6: With permit_i low, both drive outputs are low one cycle later, whatever the requests are. When permit_i returns high, the outputs follow the requests again one cycle later.
- R7: A request change that lasts fewer than FILT_CYCLES cycles leaves all outputs unchanged. A change that lasts exactly FILT_CYCLES cycles is passed through.
- R8: A request change reaches the outputs FILT_CYCLES+1 cycles after the first clock edge that samples it. With FILT_CYCLES=0 this is 1 cycle. The outputs keep their old value in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_a_i | input | 1 | On-request for the high-side switch |
| req_b_i | input | 1 | On-request for the low-side switch |
| permit_i | input | 1 | Output permit; low forces both drives off |
| drv_a_o | output | 1 | Registered drive for the high-side switch |
| drv_b_o | output | 1 | Registered drive for the low-side switch |
| clash_o | output | 1 | High while both filtered requests are high |

## Verification
A request change is due at the outputs FILT_CYCLES+1 edges after the first edge that samples it. A change that touches only the permit is due one edge later.

For every change, the driver task queues two expectations: the old output state due one cycle before the change should land, and the new state due on that cycle. The monitor compares the queue entry whose due cycle matches its free-running edge count, sampling 2 ns after each rising edge.

Pulses that are too short are checked at both the cycle a real change would have landed and after the pulse has gone. This confirms that nothing leaked through.

// File: rtl/stg_pkg.sv
package stg_pkg;

   // index of each drive channel inside the packed request vector
   localparam int unsigned CH_A   = 0;
   localparam int unsigned CH_B   = 1;
   localparam int unsigned NUM_CH = 2;

   typedef struct packed {
      logic clash;
      logic drv_b;
      logic drv_a;
   } drive_t;

   // interlock truth table on filtered requests
   function automatic drive_t interlock(input logic a, input logic b, input logic permit);
      drive_t d;
      d.clash = a & b;
      d.drv_a = permit & a & ~b;
      d.drv_b = permit & b & ~a;
      return d;
   endfunction

endpackage

// File: rtl/stg_deglitch.sv
module stg_deglitch #(
   parameter int unsigned WINDOW = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic raw_i,
   output logic filt_o
);

   if (WINDOW > 65535) begin : g_chk_window
      $error("stg_deglitch: WINDOW out of range");
   end

   if (WINDOW == 0) begin : g_bypass
      assign filt_o = raw_i;
   end else begin : g_filter
      localparam int unsigned CW = (WINDOW < 2) ? 1 : $clog2(WINDOW);
      localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

      logic [CW-1:0] run_q;
      logic          filt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            run_q  <= '0;
            filt_q <= 1'b0;
         end else if (raw_i == filt_q) begin
            run_q  <= '0;
         end else if (run_q == LAST) begin
            run_q  <= '0;
            filt_q <= raw_i;
         end else begin
            run_q  <= run_q + 1'b1;
         end
      end

      assign filt_o = filt_q;

      AST_FILT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (raw_i == filt_q) |=> $stable(filt_q)); // R7

      AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (run_q <= LAST)); // R7
   end

endmodule

// File: rtl/stg_decide.sv
module stg_decide
   import stg_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fa_i,
   input  logic fb_i,
   input  logic permit_i,
   output logic drv_a_o,
   output logic drv_b_o,
   output logic clash_o
);

   drive_t nxt, cur_q;

   always_comb nxt = interlock(fa_i, fb_i, permit_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cur_q <= '0;
      else         cur_q <= nxt;
   end

   assign drv_a_o = cur_q.drv_a;
   assign drv_b_o = cur_q.drv_b;
   assign clash_o = cur_q.clash;

   AST_A_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (permit_i && fa_i && !fb_i) |=> (drv_a_o && !drv_b_o)); // R1

   AST_B_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (permit_i && fb_i && !fa_i) |=> (drv_b_o && !drv_a_o)); // R2

   AST_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fa_i && fb_i) |=> (clash_o && !drv_a_o && !drv_b_o)); // R4

   AST_NEVER_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(drv_a_o && drv_b_o)); // R4

   AST_PERMIT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !permit_i |=> (!drv_a_o && !drv_b_o)); // R6

   AST_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fa_i && !fb_i) |=> (!drv_a_o && !drv_b_o && !clash_o)); // R3

endmodule

// File: rtl/shoot_thru_guard.sv
module shoot_thru_guard
   import stg_pkg::*;
#(
   parameter int unsigned FILT_CYCLES = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_a_i,
   input  logic req_b_i,
   input  logic permit_i,
   output logic drv_a_o,
   output logic drv_b_o,
   output logic clash_o
);

   logic [NUM_CH-1:0] raw;
   logic [NUM_CH-1:0] filt;

   assign raw[CH_A] = req_a_i;
   assign raw[CH_B] = req_b_i;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      stg_deglitch #(.WINDOW(FILT_CYCLES)) u_flt (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .raw_i  (raw[i]),
         .filt_o (filt[i])
      );
   end

   stg_decide u_dec (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .fa_i     (filt[CH_A]),
      .fb_i     (filt[CH_B]),
      .permit_i (permit_i),
      .drv_a_o  (drv_a_o),
      .drv_b_o  (drv_b_o),
      .clash_o  (clash_o)
   );

   AST_CLASH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clash_o |-> (!drv_a_o && !drv_b_o)); // R4

   AST_RESET_OFF: assert property (@(posedge clk_i)
      $rose(rst_ni) |-> (!drv_a_o && !drv_b_o && !clash_o)); // R3

endmodule

// File: tb/shoot_thru_guard_tb_top.sv
module shoot_thru_guard_tb_top;

   localparam int FILT = 3;
   localparam int LAT  = (FILT == 0) ? 1 : FILT + 1;

   typedef struct {
      int   due;
      logic a;
      logic b;
      logic c;
      int   req;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ra = 1'b0, rb = 1'b0, pm = 1'b0;
   logic da, db, cl;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit done = 0;
   exp_t q[$];

   logic cur_a = 1'b0, cur_b = 1'b0, cur_p = 1'b0;

   always #4 clk = ~clk;

   shoot_thru_guard #(.FILT_CYCLES(FILT)) dut_i (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .req_a_i  (ra),
      .req_b_i  (rb),
      .permit_i (pm),
      .drv_a_o  (da),
      .drv_b_o  (db),
      .clash_o  (cl)
   );

   always @(posedge clk) cyc <= cyc + 1;

   function automatic exp_t model(input logic a, input logic b, input logic p,
                                  input int due, input int req);
      exp_t e;
      e.due = due;
      e.a   = p & a & ~b;
      e.b   = p & b & ~a;
      e.c   = a & b;
      e.req = req;
      return e;
   endfunction

   task automatic cmp(input exp_t e);
      checks++;
      if ({da, db, cl} !== {e.a, e.b, e.c}) begin
         errors++;
         $display("FAIL R%0d cycle %0d: actual a=%b b=%b clash=%b expected a=%b b=%b clash=%b",
                  e.req, cyc, da, db, cl, e.a, e.b, e.c);
      end
   endtask

   // monitor: pops entries due in the current cycle
   initial begin
      forever begin
         @(posedge clk);
         #2;
         while (q.size() > 0 && q[0].due <= cyc) begin
            if (q[0].due < cyc) begin
               checks++;
               errors++;
               $display("FAIL R%0d missed due cycle: actual cycle %0d expected %0d",
                        q[0].req, cyc, q[0].due);
               void'(q.pop_front());
            end else begin
               cmp(q.pop_front());
            end
         end
      end
   end

   // driver: settled change; queues old state one cycle early (R8) and new state on time
   task automatic step(input logic a, input logic b, input logic p, input int req);
      int c, lat;
      lat = ((a != cur_a) || (b != cur_b)) ? LAT : 1;
      c = cyc;
      if (lat > 1) q.push_back(model(cur_a, cur_b, p, c + lat - 1, 8)); // R8 pre check
      q.push_back(model(a, b, p, c + lat, req));
      ra = a; rb = b; pm = p;
      cur_a = a; cur_b = b; cur_p = p;
      repeat (lat + 1) @(negedge clk);
   endtask

   // pulse of w cycles, then back to the settled request
   task automatic pulse(input logic a, input logic b, input int w, input bit pass);
      int c;
      c = cyc;
      if (pass) q.push_back(model(a, b, cur_p, c + LAT, 7));
      else      q.push_back(model(cur_a, cur_b, cur_p, c + LAT, 7));
      q.push_back(model(cur_a, cur_b, cur_p, c + w + LAT, 7));
      ra = a; rb = b;
      repeat (w) @(negedge clk);
      ra = cur_a; rb = cur_b;
      repeat (LAT + 1) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R3: reset state
      checks++;
      if ({da, db, cl} !== 3'b000) begin
         errors++;
         $display("FAIL R3 reset: actual %b%b%b expected 000", da, db, cl);
      end
      rst_n = 1'b1;
      pm = 1'b1; cur_p = 1'b1;
      repeat (2) @(negedge clk);

      step(1'b1, 1'b0, 1'b1, 1);  // R1
      step(1'b0, 1'b0, 1'b1, 3);  // R3
      step(1'b0, 1'b1, 1'b1, 2);  // R2
      step(1'b1, 1'b1, 1'b1, 4);  // R4 contention
      step(1'b0, 1'b1, 1'b1, 5);  // R5 A falls first -> B on
      step(1'b1, 1'b1, 1'b1, 4);  // R4
      step(1'b1, 1'b0, 1'b1, 5);  // R5 B falls first -> A on
      step(1'b1, 1'b0, 1'b0, 6);  // R6 permit low
      step(1'b0, 1'b1, 1'b0, 6);  // R6 inputs ignored while off
      step(1'b0, 1'b1, 1'b1, 6);  // R6 permit back
      pulse(1'b1, 1'b1, FILT - 1, 1'b0); // R7 short glitch into contention
      pulse(1'b0, 1'b0, 1, 1'b0);        // R7 single-cycle dropout
      pulse(1'b1, 1'b0, FILT, 1'b1);     // R7 exact-window pulse passes
      step(1'b0, 1'b0, 1'b1, 3);  // R3 / R8
      step(1'b1, 1'b0, 1'b1, 1);  // R1 / R8
      repeat (4) @(negedge clk);
      done = 1;
   end

   initial begin
      fork
         wait (done == 1);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      if (q.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule